// File: doc/BRIEF.md
# Flash Read-Protection Guard

This block sets the read-protection level of an embedded flash and enforces it on every access. The level comes from a stored key byte and its complement. Exactly one pair selects the open level and exactly one other pair selects the locked level. Every other pair, including the erased all-ones state, selects the guarded middle level. The level is captured in a register only while reset is held or when an option-byte load completes. A change on the stored bytes at any other time has no effect.

Each access request carries a region (main array, option bytes, backup registers, system memory) and an operation (read, program, erase). The block answers every request with either a one-cycle grant or a one-cycle bus-error pulse, and a fault-interrupt pulse goes with each bus error. The decision depends on the level, the boot source and whether a debugger is attached. The block also drives the debug-port enable and a boot-permit flag.

A key-write sequencer screens requests to write a new key byte. When the level is being lowered and the erase-on-regression control is set, the sequencer first holds a mass-erase request until the erase finishes. Only then does it issue the key-programming pulse.

Top module: `flash_rdp_guard`

## Requirements
- R1: With key/complement 0xAA/0x55 `level` reads 0, with 0xCC/0x33 it reads 2, and with any other pair (including 0xFF/0xFF) it reads 1; the pair is captured while `rst` is high or on a cycle with `ob_load` high, and `level` shows it one cycle later.
- R2: When `ob_load` is low and `rst` is low, a change on `ob_key`/`ob_key_n` leaves `level` unchanged.
- R3: At level 0, every operation on region 0 (main), 1 (option bytes) and 2 (backup) is granted, whatever the boot source and debug state.
- R4: At level 1 or 2, when `dbg_active` is high or `boot_src` is not 0 (flash), a request to region 0 or 2 is refused: `bus_err` and `fault_irq` pulse high for one cycle and `grant` stays low; region 1 is still granted.
- R5: At level 1 or 2, with `boot_src` = 0 and `dbg_active` low, every operation on regions 0, 1 and 2 is granted.
- R6: A read (op 0) of region 3 (system memory) is granted at every level and in every context; program (op 1) or erase (op 2, 3) of region 3 is always refused.
- R7: The answer to a request sampled on a clock edge appears in the following cycle as exactly one of `grant` or `bus_err`, for one cycle; with `req_valid` low, neither is raised.
- R8: `dbg_port_en` is 0 while `rst` is high and while the level is 2, and 1 otherwise, following the level with one cycle of lag.
- R9: `boot_permit` is 0 exactly when the level is 2 and `boot_src` is not 0.
- R10: At level 2 every key-write request is refused with a one-cycle `key_reject` pulse and no `key_prog` pulse.
- R11: At level 0 any key byte is accepted, and at level 1 any byte other than 0xAA (and 0xAA when `erase_on_regress` is 0) is accepted: `key_prog` pulses in the next cycle with `key_prog_byte` equal to the written byte.
- R12: At level 1 with `erase_on_regress` = 1, writing 0xAA raises `mass_erase_req` from the next cycle and holds it until `mass_erase_done` is sampled high. `key_prog` pulses with byte 0xAA in the cycle after that sample, and not before.
- R13: A key-write request that arrives while a mass erase is pending is refused with a `key_reject` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; level captured while high |
| ob_key | input | 8 | Stored protection key byte |
| ob_key_n | input | 8 | Stored complement of the key byte |
| ob_load | input | 1 | Option-byte load completed; capture the level |
| boot_src | input | 2 | 0 flash, 1 SRAM, 2 system memory, 3 treated as non-flash |
| dbg_active | input | 1 | Debugger attached |
| req_valid | input | 1 | Access request strobe |
| req_region | input | 2 | 0 main, 1 option bytes, 2 backup, 3 system memory |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 erase |
| grant | output | 1 | Request allowed (one-cycle pulse) |
| bus_err | output | 1 | Request refused (one-cycle pulse) |
| fault_irq | output | 1 | Fault interrupt pulse with each refusal |
| level | output | 2 | Current protection level 0, 1 or 2 |
| dbg_port_en | output | 1 | Debug-port enable |
| boot_permit | output | 1 | Current boot source allowed |
| key_wr_valid | input | 1 | Request to write a new key byte |
| key_wr_byte | input | 8 | Requested key byte |
| erase_on_regress | input | 1 | Force mass erase before lowering 1 to 0 |
| mass_erase_req | output | 1 | Mass erase of the main array requested |
| mass_erase_done | input | 1 | Mass erase finished |
| key_prog | output | 1 | Program the key byte (one-cycle pulse) |
| key_prog_byte | output | 8 | Byte to program |
| key_reject | output | 1 | Key write refused (one-cycle pulse) |

## Verification
Access answers, key-write answers and the level change all show up in the cycle after the edge that samples the stimulus. The bench drives inputs on the falling edge and checks one falling edge later, then clears the strobe so that every pulse is checked in the single cycle it should occupy. The debug-port enable lags the level by one more register, so it is checked two falling edges after a load. The boot-permit flag is combinational from the level, so it is checked in the same cycle as the level. The mass-erase request is checked on several cycles while the erase is pending. Once the done input is raised, the programming pulse is expected exactly one cycle later.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    localparam int KEY_W = 8;
    localparam logic [KEY_W-1:0] KEY_OPEN = 8'hAA;
    localparam logic [KEY_W-1:0] KEY_LOCK = 8'hCC;

    typedef enum logic [1:0] {LVL_OPEN = 2'd0, LVL_GUARD = 2'd1, LVL_LOCK = 2'd2} rdp_lvl_e;
    typedef enum logic [1:0] {BOOT_FLASH = 2'd0, BOOT_SRAM = 2'd1, BOOT_SYSMEM = 2'd2, BOOT_RSVD = 2'd3} boot_e;
    typedef enum logic [1:0] {RG_MAIN = 2'd0, RG_OPT = 2'd1, RG_BKP = 2'd2, RG_SYS = 2'd3} region_e;
    typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_ERASE2 = 2'd3} op_e;
    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ERASE = 1'b1} seq_e;

    typedef struct packed {
        region_e region;
        op_e     op;
    } acc_req_t;

    typedef struct packed {
        boot_e boot;
        logic  dbg;
    } ctx_t;

    function automatic rdp_lvl_e decode_level(input logic [KEY_W-1:0] key, input logic [KEY_W-1:0] key_n);
        if (key == KEY_OPEN && key_n == ~KEY_OPEN) return LVL_OPEN;
        if (key == KEY_LOCK && key_n == ~KEY_LOCK) return LVL_LOCK;
        return LVL_GUARD;
    endfunction

    function automatic logic ctx_restricted(input ctx_t c);
        return c.dbg || (c.boot != BOOT_FLASH);
    endfunction
endpackage

// File: rtl/rdp_level_reg.sv
module rdp_level_reg
    import rdp_pkg::*;
#(
    parameter int KW = KEY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [KW-1:0] key,
    input  logic [KW-1:0] key_n,
    input  logic          load,
    output rdp_lvl_e      level_q
);
    always_ff @(posedge clk) begin
        if (rst || load) level_q <= decode_level(key, key_n);
    end

    // R2
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(level_q));
endmodule

// File: rtl/rdp_access_check.sv
module rdp_access_check
    import rdp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rdp_lvl_e level,
    input  ctx_t     ctx,
    input  logic     req_valid,
    input  acc_req_t req,
    output logic     grant_q,
    output logic     err_q
);
    logic allow;

    always_comb begin
        allow = 1'b1;
        if (req.region == RG_SYS) begin
            allow = (req.op == OP_READ);
        end else if (level != LVL_OPEN && ctx_restricted(ctx) &&
                     (req.region == RG_MAIN || req.region == RG_BKP)) begin
            allow = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            grant_q <= req_valid && allow;
            err_q   <= req_valid && !allow;
        end
    end

    // R6
    sys_write_refused_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req.region == RG_SYS && req.op != OP_READ |=> err_q && !grant_q);
    // R3
    open_level_grant_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && level == LVL_OPEN && req.region != RG_SYS |=> grant_q && !err_q);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !grant_q && !err_q);
endmodule

// File: rtl/rdp_key_seq.sv
module rdp_key_seq
    import rdp_pkg::*;
#(
    parameter int KW = KEY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  rdp_lvl_e      level,
    input  logic          wr_valid,
    input  logic [KW-1:0] wr_byte,
    input  logic          erase_on_regress,
    input  logic          erase_done,
    output logic          erase_req,
    output logic          prog_q,
    output logic [KW-1:0] prog_byte_q,
    output logic          reject_q
);
    seq_e st;
    logic regress;

    assign regress   = (level == LVL_GUARD) && (wr_byte == KEY_OPEN) && erase_on_regress;
    assign erase_req = (st == SEQ_ERASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= SEQ_IDLE;
            prog_q      <= 1'b0;
            reject_q    <= 1'b0;
            prog_byte_q <= '0;
        end else begin
            prog_q   <= 1'b0;
            reject_q <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (wr_valid) begin
                        if (level == LVL_LOCK) begin
                            reject_q <= 1'b1;
                        end else if (regress) begin
                            st          <= SEQ_ERASE;
                            prog_byte_q <= wr_byte;
                        end else begin
                            prog_q      <= 1'b1;
                            prog_byte_q <= wr_byte;
                        end
                    end
                end
                SEQ_ERASE: begin
                    if (wr_valid) reject_q <= 1'b1;
                    if (erase_done) begin
                        st     <= SEQ_IDLE;
                        prog_q <= 1'b1;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // R10
    lock_write_reject_chk: assert property (@(posedge clk) disable iff (rst)
        st == SEQ_IDLE && wr_valid && level == LVL_LOCK |=> reject_q && !prog_q);
    // R12
    erase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        st == SEQ_ERASE && !erase_done |=> erase_req && !prog_q);
    // R13
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        st == SEQ_ERASE && wr_valid |=> reject_q);
endmodule

// File: rtl/flash_rdp_guard.sv
module flash_rdp_guard
    import rdp_pkg::*;
#(
    parameter int KW = KEY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [KW-1:0] ob_key,
    input  logic [KW-1:0] ob_key_n,
    input  logic          ob_load,
    input  logic [1:0]    boot_src,
    input  logic          dbg_active,
    input  logic          req_valid,
    input  logic [1:0]    req_region,
    input  logic [1:0]    req_op,
    output logic          grant,
    output logic          bus_err,
    output logic          fault_irq,
    output logic [1:0]    level,
    output logic          dbg_port_en,
    output logic          boot_permit,
    input  logic          key_wr_valid,
    input  logic [KW-1:0] key_wr_byte,
    input  logic          erase_on_regress,
    output logic          mass_erase_req,
    input  logic          mass_erase_done,
    output logic          key_prog,
    output logic [KW-1:0] key_prog_byte,
    output logic          key_reject
);
    rdp_lvl_e lvl_q;
    ctx_t     ctx;
    acc_req_t req;
    logic     dbg_en_q;

    assign ctx.boot   = boot_e'(boot_src);
    assign ctx.dbg    = dbg_active;
    assign req.region = region_e'(req_region);
    assign req.op     = op_e'(req_op);

    rdp_level_reg #(.KW(KW)) u_level (
        .clk(clk), .rst(rst), .key(ob_key), .key_n(ob_key_n),
        .load(ob_load), .level_q(lvl_q)
    );

    rdp_access_check u_access (
        .clk(clk), .rst(rst), .level(lvl_q), .ctx(ctx),
        .req_valid(req_valid), .req(req), .grant_q(grant), .err_q(bus_err)
    );

    rdp_key_seq #(.KW(KW)) u_seq (
        .clk(clk), .rst(rst), .level(lvl_q), .wr_valid(key_wr_valid),
        .wr_byte(key_wr_byte), .erase_on_regress(erase_on_regress),
        .erase_done(mass_erase_done), .erase_req(mass_erase_req),
        .prog_q(key_prog), .prog_byte_q(key_prog_byte), .reject_q(key_reject)
    );

    always_ff @(posedge clk) begin
        if (rst) dbg_en_q <= 1'b0;
        else     dbg_en_q <= (lvl_q != LVL_LOCK);
    end

    assign dbg_port_en = dbg_en_q;
    assign fault_irq   = bus_err;
    assign level       = lvl_q;
    assign boot_permit = !(lvl_q == LVL_LOCK && ctx.boot != BOOT_FLASH);

    // R8
    reset_dbg_off_chk: assert property (@(posedge clk) rst |=> !dbg_port_en);
    // R8
    lock_dbg_off_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_q == LVL_LOCK && !ob_load |=> !dbg_port_en);
    // R4
    restricted_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && lvl_q != LVL_OPEN && (dbg_active || boot_src != 2'd0) &&
        (req_region == 2'd0 || req_region == 2'd2) |=> bus_err && fault_irq && !grant);
endmodule

// File: tb/flash_rdp_guard_bench.sv
module flash_rdp_guard_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] ob_key, ob_key_n;
    logic       ob_load;
    logic [1:0] boot_src;
    logic       dbg_active;
    logic       req_valid;
    logic [1:0] req_region, req_op;
    logic       grant, bus_err, fault_irq;
    logic [1:0] level;
    logic       dbg_port_en, boot_permit;
    logic       key_wr_valid;
    logic [7:0] key_wr_byte;
    logic       erase_on_regress;
    logic       mass_erase_req, mass_erase_done;
    logic       key_prog;
    logic [7:0] key_prog_byte;
    logic       key_reject;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flash_rdp_guard u_flash_rdp_guard (
        .clk(clk), .rst(rst), .ob_key(ob_key), .ob_key_n(ob_key_n), .ob_load(ob_load),
        .boot_src(boot_src), .dbg_active(dbg_active), .req_valid(req_valid),
        .req_region(req_region), .req_op(req_op), .grant(grant), .bus_err(bus_err),
        .fault_irq(fault_irq), .level(level), .dbg_port_en(dbg_port_en),
        .boot_permit(boot_permit), .key_wr_valid(key_wr_valid), .key_wr_byte(key_wr_byte),
        .erase_on_regress(erase_on_regress), .mass_erase_req(mass_erase_req),
        .mass_erase_done(mass_erase_done), .key_prog(key_prog),
        .key_prog_byte(key_prog_byte), .key_reject(key_reject)
    );

    function automatic int model_level(input logic [7:0] k, input logic [7:0] kn);
        if (k == 8'hAA && kn == 8'h55) return 0;
        if (k == 8'hCC && kn == 8'h33) return 2;
        return 1;
    endfunction

    function automatic bit model_allow(input int lv, input logic [1:0] bs, input logic dbg,
                                       input logic [1:0] rg, input logic [1:0] op);
        if (rg == 2'd3) return (op == 2'd0);
        if (lv == 0) return 1'b1;
        if ((dbg || bs != 2'd0) && (rg == 2'd0 || rg == 2'd2)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_pair(input logic [7:0] k, input logic [7:0] kn);
        ob_key = k; ob_key_n = kn; ob_load = 1'b1;
        @(negedge clk);
        ob_load = 1'b0;
    endtask

    task automatic access(input string req, input logic [1:0] bs, input logic dbg,
                          input logic [1:0] rg, input logic [1:0] op);
        bit exp;
        exp = model_allow(int'(level), bs, dbg, rg, op);
        boot_src = bs; dbg_active = dbg; req_region = rg; req_op = op; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(grant == exp && bus_err == !exp && fault_irq == !exp, req, "grant/bus_err/fault",
              {grant, bus_err, fault_irq}, {exp, !exp, !exp});
        @(negedge clk);
        check(!grant && !bus_err, "R7", "pulse width", {grant, bus_err}, 0);
    endtask

    task automatic key_write(input logic [7:0] b);
        key_wr_byte = b; key_wr_valid = 1'b1;
        @(negedge clk);
        key_wr_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; ob_key = 8'hFF; ob_key_n = 8'hFF; ob_load = 1'b0;
        boot_src = 2'd0; dbg_active = 1'b0; req_valid = 1'b0; req_region = 2'd0; req_op = 2'd0;
        key_wr_valid = 1'b0; key_wr_byte = 8'h00; erase_on_regress = 1'b0; mass_erase_done = 1'b0;
        repeat (3) @(negedge clk);
        // R1 erased pair decodes to level 1; R8 debug off in reset
        check(level == 2'd1, "R1", "erased level", level, 1);
        check(!dbg_port_en, "R8", "dbg in reset", dbg_port_en, 0);
        check(!grant && !bus_err && !key_prog && !key_reject && !mass_erase_req, "R7", "reset outputs",
              {grant, bus_err, key_prog, key_reject, mass_erase_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(dbg_port_en, "R8", "dbg after reset", dbg_port_en, 1);

        // R1 the three decodes
        load_pair(8'hAA, 8'h55); check(level == 2'd0, "R1", "AA/55", level, 0);
        load_pair(8'hAA, 8'h54); check(level == 2'd1, "R1", "AA/54", level, 1);
        load_pair(8'hCC, 8'h33); check(level == 2'd2, "R1", "CC/33", level, 2);
        // R8 lag and R9 boot permit
        check(dbg_port_en, "R8", "dbg lag", dbg_port_en, 1);
        @(negedge clk);
        check(!dbg_port_en, "R8", "dbg at lock", dbg_port_en, 0);
        boot_src = 2'd1; #1;
        check(!boot_permit, "R9", "sram boot at lock", boot_permit, 0);
        boot_src = 2'd0; #1;
        check(boot_permit, "R9", "flash boot at lock", boot_permit, 1);
        // R2 key change without load is ignored
        ob_key = 8'hAA; ob_key_n = 8'h55;
        repeat (2) @(negedge clk);
        check(level == 2'd2, "R2", "no load no change", level, 2);
        // R10 write at lock refused
        key_write(8'hAA);
        check(key_reject && !key_prog, "R10", "lock write", {key_reject, key_prog}, 2);
        // R4 locked, SRAM boot refuses main; R5 flash boot grants; R6 sysmem
        access("R4", 2'd1, 1'b0, 2'd0, 2'd0);
        access("R4", 2'd0, 1'b1, 2'd2, 2'd1);
        access("R4", 2'd2, 1'b0, 2'd1, 2'd0);
        access("R5", 2'd0, 1'b0, 2'd0, 2'd2);
        access("R6", 2'd1, 1'b1, 2'd3, 2'd0);
        access("R6", 2'd0, 1'b0, 2'd3, 2'd1);

        // R3 open level, debug attached
        load_pair(8'hAA, 8'h55);
        boot_src = 2'd1; #1;
        check(boot_permit, "R9", "sram boot at open", boot_permit, 1);
        access("R3", 2'd1, 1'b1, 2'd0, 2'd2);
        access("R3", 2'd2, 1'b1, 2'd2, 2'd0);
        access("R6", 2'd0, 1'b0, 2'd3, 2'd2);
        // R11 any byte at open accepted
        key_write(8'h5A);
        check(key_prog && key_prog_byte == 8'h5A && !key_reject, "R11", "open write", key_prog_byte, 8'h5A);

        // R11 level 1, 0xAA without erase control
        load_pair(8'h12, 8'hED);
        key_write(8'hAA);
        check(key_prog && key_prog_byte == 8'hAA && !mass_erase_req, "R11", "regress no erase", key_prog, 1);
        key_write(8'hCC);
        check(key_prog && key_prog_byte == 8'hCC, "R11", "guard to lock", key_prog_byte, 8'hCC);

        // R12 regression with erase
        erase_on_regress = 1'b1;
        key_write(8'hAA);
        check(mass_erase_req && !key_prog, "R12", "erase start", {mass_erase_req, key_prog}, 2);
        // R13 write while erase pending
        key_write(8'h33);
        check(key_reject && !key_prog, "R13", "busy write", {key_reject, key_prog}, 2);
        repeat (3) @(negedge clk);
        check(mass_erase_req && !key_prog, "R12", "erase held", {mass_erase_req, key_prog}, 2);
        mass_erase_done = 1'b1;
        @(negedge clk);
        mass_erase_done = 1'b0;
        check(key_prog && key_prog_byte == 8'hAA && !mass_erase_req, "R12", "prog after erase",
              {key_prog, key_prog_byte}, {1'b1, 8'hAA});
        @(negedge clk);
        check(!key_prog, "R12", "single prog", key_prog, 0);
        erase_on_regress = 1'b0;

        // Random mix
        process::self().srandom(32'd1234);
        for (int i = 0; i < 300; i++) begin
            logic [7:0] k, kn;
            int sel;
            sel = $urandom_range(0, 3);
            case (sel)
                0: begin k = 8'hAA; kn = 8'h55; end
                1: begin k = 8'hCC; kn = 8'h33; end
                2: begin k = 8'hFF; kn = 8'hFF; end
                default: begin k = 8'($urandom); kn = 8'($urandom); end
            endcase
            load_pair(k, kn);
            check(int'(level) == model_level(k, kn), "R1", "random decode", level, model_level(k, kn));
            access("R4", 2'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual 0 expected 1");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule